// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the machine-mode registers for a small bank of address/data match triggers in a RISC-V style core. The core's CSR unit presents an address, write data and a write enable. Four addresses are decoded: a selection register that names one trigger, that trigger's control word, its compare value, and a third data register that is not implemented. Reads are combinational and return legal data only.

Every control word written is passed through a write-any-read-legal filter before it is stored. The trigger type is pinned to address/data match (code 2). The debug-mode bit and all unimplemented fields read as zero. A size code that is not supported is replaced by "any size". For each trigger, the block exports the stored control word and compare value to a separate match unit. It also raises a one-cycle pulse when a write really alters either of them, so that the match unit can reload its state.

Top module: `dtrig_csr_bank`

## Requirements
- R1: After reset the selection register is 0. Every trigger's control word is 0x2000_0000_0000_0000, which is type 2 in bits [63:60] and all else zero. Every compare value is 0 and no change pulse is high.
- R2: All bits of the selection register (address 0x7A0) are writable and read back exactly as written.
- R3: Bits [63:60] of every control word (address 0x7A1) always read 4'd2, and bit 59 (debug mode) always reads 0, whatever value is written.
- R4: Only these control-word bits are stored: load (bit 0), store (bit 1), execute (bit 2), user (bit 3), supervisor (bit 4) and machine (bit 6). They keep exactly the value written.
- R5: All other control-word bits read zero. This covers bit 5, bits [15:7], bits [20:18], bits [58:23] and the chain, action, timing, select, hit and match fields.
- R6: The size code is {bits[22:21], bits[17:16]} of the written word. Codes 0, 1, 2, 3 and 5 are stored unchanged in those bits. Code 4 and codes 6 to 15 store 0 in all four bits.
- R7: The compare value (address 0x7A2) stores all written bits, reads them back, and is exported unchanged.
- R8: When the selection register holds a value of 2 or more (the full register width is compared), reads of 0x7A1, 0x7A2 and 0x7A3 return zero. Writes to those addresses change no trigger.
- R9: Writes to 0x7A3 change nothing, and reads of 0x7A3 return zero.
- R10: A change pulse for trigger i is high for exactly one cycle, in the cycle after a write to trigger i that alters its stored control word or compare value. A write that stores an identical value raises no pulse. At most one pulse is high at a time.
- R11: The exported control words and compare values, trigger i at bits [64*i+63:64*i], always equal the stored registers. A write touches only the selected trigger.
- R12: A write to any address other than 0x7A0 to 0x7A3 has no effect, and a read of such an address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_addr | input | 12 | CSR address for the read and write |
| csr_wdata | input | XLEN (64) | Write data |
| csr_we | input | 1 | Write enable, applied at the clock edge |
| csr_rdata | output | XLEN (64) | Combinational read data for csr_addr |
| trig_ctrl | output | NUM_TRIG*XLEN (128) | Stored control words, trigger i in slice i |
| trig_cmp | output | NUM_TRIG*XLEN (128) | Stored compare values, trigger i in slice i |
| trig_changed | output | NUM_TRIG (2) | One-cycle pulse per trigger after a value-changing write |

## Verification
The hardest cases to reach from the ports involve states that a plain write cannot show. The first is a write that leaves a register unchanged, where the missing pulse is the only thing to observe. The second is a selection value whose low bits name a real trigger while its high bits put it out of range. The third is the set of size codes that use the upper size bits. Random stimulus mixes wide random selection values with small ones, and it sometimes rewrites the filtered image of the current control word. A directed sweep covers all sixteen size codes. After every write the bench compares both triggers' exports and the pulse vector with a model.

// File: rtl/dtrig_pkg.sv
// Package: shared constants, address decode and size-code legality for the
// debug trigger register bank. Assumes standard machine-mode trigger CSR
// addresses and a control word of at least 32 bits.
package dtrig_pkg;

    localparam logic [11:0] ADDR_TSEL = 12'h7A0;
    localparam logic [11:0] ADDR_TD1  = 12'h7A1;
    localparam logic [11:0] ADDR_TD2  = 12'h7A2;
    localparam logic [11:0] ADDR_TD3  = 12'h7A3;

    localparam logic [3:0] MATCH_TYPE = 4'd2;

    localparam int BIT_LD   = 0;
    localparam int BIT_ST   = 1;
    localparam int BIT_EX   = 2;
    localparam int BIT_PU   = 3;
    localparam int BIT_PS   = 4;
    localparam int BIT_PM   = 6;
    localparam int SZLO_LSB = 16;
    localparam int SZHI_LSB = 21;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_TSEL,
        SEL_TD1,
        SEL_TD2,
        SEL_TD3
    } csr_sel_e;

    // Map a CSR address onto the register it names.
    function automatic csr_sel_e decode_addr(input logic [11:0] a);
        case (a)
            ADDR_TSEL: return SEL_TSEL;
            ADDR_TD1:  return SEL_TD1;
            ADDR_TD2:  return SEL_TD2;
            ADDR_TD3:  return SEL_TD3;
            default:   return SEL_NONE;
        endcase
    endfunction

    // True for the access-size codes the match unit supports.
    function automatic logic size_code_ok(input logic [3:0] c);
        return (c == 4'd0) || (c == 4'd1) || (c == 4'd2) ||
               (c == 4'd3) || (c == 4'd5);
    endfunction

endpackage

// File: rtl/dtrig_ctrl_filter.sv
// Module: dtrig_ctrl_filter
// Turns a raw control-word write into its legal stored form. It forces the
// type to address/data match, keeps the permission and access bits, keeps a
// supported size code (else any size), and clears every other bit.
// Assumes XLEN is 32 or 64. The upper size bits exist only when XLEN is 64.
module dtrig_ctrl_filter
    import dtrig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] raw,
    output logic [XLEN-1:0] legal
);
    localparam bit HAS_SZHI = (XLEN >= 64);

    logic [1:0] sz_hi;
    logic [3:0] sz_code;

    // Pick the upper size bits only where the width provides them.
    generate
        if (HAS_SZHI) begin : g_szhi
            assign sz_hi = raw[SZHI_LSB+1:SZHI_LSB];
        end else begin : g_noszhi
            assign sz_hi = 2'b00;
        end
    endgenerate

    assign sz_code = {sz_hi, raw[SZLO_LSB+1:SZLO_LSB]};

    // Build the legal word field by field.
    always_comb begin
        legal = '0;
        legal[XLEN-1 -: 4] = MATCH_TYPE;
        legal[BIT_LD] = raw[BIT_LD];
        legal[BIT_ST] = raw[BIT_ST];
        legal[BIT_EX] = raw[BIT_EX];
        legal[BIT_PU] = raw[BIT_PU];
        legal[BIT_PS] = raw[BIT_PS];
        legal[BIT_PM] = raw[BIT_PM];
        if (size_code_ok(sz_code)) begin
            legal[SZLO_LSB+1:SZLO_LSB] = sz_code[1:0];
            if (HAS_SZHI) begin
                legal[SZHI_LSB+1:SZHI_LSB] = sz_code[3:2];
            end
        end
    end
endmodule

// File: rtl/dtrig_slot.sv
// Module: dtrig_slot
// Storage for one trigger: its control word and compare value, plus a
// registered pulse when a write alters either. Assumes that the caller
// asserts at most one write strobe per cycle and that ctrl_new is
// already legal.
module dtrig_slot
    import dtrig_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_ctrl,
    input  logic            wr_cmp,
    input  logic [XLEN-1:0] ctrl_new,
    input  logic [XLEN-1:0] cmp_new,
    output logic [XLEN-1:0] ctrl_q,
    output logic [XLEN-1:0] cmp_q,
    output logic            changed_q
);
    localparam logic [XLEN-1:0] CTRL_RESET = {MATCH_TYPE, {(XLEN-4){1'b0}}};

    logic ctrl_diff;
    logic cmp_diff;

    assign ctrl_diff = wr_ctrl && (ctrl_new != ctrl_q);
    assign cmp_diff  = wr_cmp  && (cmp_new  != cmp_q);

    // Hold the control word; reload it on a strobed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_new;
        end
    end

    // Hold the compare value; reload it on a strobed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (wr_cmp) begin
            cmp_q <= cmp_new;
        end
    end

    // Pulse for one cycle after a write that changed a stored value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            changed_q <= 1'b0;
        end else begin
            changed_q <= ctrl_diff || cmp_diff;
        end
    end
endmodule

// File: rtl/dtrig_read_mux.sv
// Module: dtrig_read_mux
// Combinational read path. It returns the selection register, or the
// selected trigger's control word or compare value, and zero for the
// unimplemented register, an out-of-range selection or an unknown address.
module dtrig_read_mux
    import dtrig_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NUM_TRIG = 2,
    parameter int IDX_W    = 1
) (
    input  csr_sel_e                 sel,
    input  logic                     sel_hit,
    input  logic [IDX_W-1:0]         sel_idx,
    input  logic [XLEN-1:0]          tsel,
    input  logic [NUM_TRIG*XLEN-1:0] ctrl_flat,
    input  logic [NUM_TRIG*XLEN-1:0] cmp_flat,
    output logic [XLEN-1:0]          rdata
);
    logic [XLEN-1:0] ctrl_pick;
    logic [XLEN-1:0] cmp_pick;

    // Gather the selected trigger's two words.
    always_comb begin
        ctrl_pick = '0;
        cmp_pick  = '0;
        for (int i = 0; i < NUM_TRIG; i++) begin
            if (sel_idx == IDX_W'(i)) begin
                ctrl_pick = ctrl_flat[i*XLEN +: XLEN];
                cmp_pick  = cmp_flat[i*XLEN +: XLEN];
            end
        end
    end

    // Steer the word named by the address onto the read bus.
    always_comb begin
        case (sel)
            SEL_TSEL: rdata = tsel;
            SEL_TD1:  rdata = sel_hit ? ctrl_pick : '0;
            SEL_TD2:  rdata = sel_hit ? cmp_pick  : '0;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dtrig_csr_bank.sv
// Module: dtrig_csr_bank (top)
// Machine-mode register bank for NUM_TRIG address/data match triggers. It
// decodes CSR accesses, holds the full-width selection register, filters
// control writes and exports every trigger's words with a change pulse.
// Assumes writes take effect at the clock edge and reads are combinational.
module dtrig_csr_bank
    import dtrig_pkg::*;
#(
    parameter int XLEN     = 64,
    parameter int NUM_TRIG = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [11:0]              csr_addr,
    input  logic [XLEN-1:0]          csr_wdata,
    input  logic                     csr_we,
    output logic [XLEN-1:0]          csr_rdata,
    output logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
    output logic [NUM_TRIG*XLEN-1:0] trig_cmp,
    output logic [NUM_TRIG-1:0]      trig_changed
);
    localparam int IDX_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

    csr_sel_e        sel;
    logic [XLEN-1:0] tsel_q;
    logic            sel_hit;
    logic [IDX_W-1:0] sel_idx;
    logic [XLEN-1:0] ctrl_legal;

    assign sel     = decode_addr(csr_addr);
    assign sel_hit = (tsel_q < XLEN'(NUM_TRIG));
    assign sel_idx = tsel_q[IDX_W-1:0];

    // Keep the selection register; every bit is writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsel_q <= '0;
        end else if (csr_we && (sel == SEL_TSEL)) begin
            tsel_q <= csr_wdata;
        end
    end

    dtrig_ctrl_filter #(.XLEN(XLEN)) u_filter (
        .raw   (csr_wdata),
        .legal (ctrl_legal)
    );

    generate
        for (genvar i = 0; i < NUM_TRIG; i++) begin : g_slot
            logic picked;
            assign picked = csr_we && sel_hit && (sel_idx == IDX_W'(i));

            dtrig_slot #(.XLEN(XLEN)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_ctrl   (picked && (sel == SEL_TD1)),
                .wr_cmp    (picked && (sel == SEL_TD2)),
                .ctrl_new  (ctrl_legal),
                .cmp_new   (csr_wdata),
                .ctrl_q    (trig_ctrl[i*XLEN +: XLEN]),
                .cmp_q     (trig_cmp[i*XLEN +: XLEN]),
                .changed_q (trig_changed[i])
            );
        end
    endgenerate

    dtrig_read_mux #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG), .IDX_W(IDX_W)) u_rmux (
        .sel       (sel),
        .sel_hit   (sel_hit),
        .sel_idx   (sel_idx),
        .tsel      (tsel_q),
        .ctrl_flat (trig_ctrl),
        .cmp_flat  (trig_cmp),
        .rdata     (csr_rdata)
    );
endmodule

// File: rtl/dtrig_csr_bank_chk.sv
// Module: dtrig_csr_bank_chk
// Property checker for the trigger register bank, bound to the top module.
module dtrig_csr_bank_chk #(
    parameter int XLEN     = 64,
    parameter int NUM_TRIG = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     csr_we,
    input logic                     sel_hit,
    input logic [NUM_TRIG*XLEN-1:0] trig_ctrl,
    input logic [NUM_TRIG*XLEN-1:0] trig_cmp,
    input logic [NUM_TRIG-1:0]      trig_changed
);
    // R10
    pulse_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|trig_changed) |-> $past(csr_we));

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig_changed));

    // R7
    cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(csr_we) |-> $stable(trig_cmp));

    // R8
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(csr_we && !sel_hit) |-> ($stable(trig_ctrl) && $stable(trig_cmp)));

    generate
        for (genvar i = 0; i < NUM_TRIG; i++) begin : g_word
            // R3
            type_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (trig_ctrl[i*XLEN+XLEN-1 -: 5] == 5'b00100));

            // R5
            reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (trig_ctrl[i*XLEN+5] == 1'b0) &&
                (trig_ctrl[i*XLEN+7 +: 9] == 9'd0) &&
                (trig_ctrl[i*XLEN+18 +: 3] == 3'd0));
        end
    endgenerate
endmodule

bind dtrig_csr_bank dtrig_csr_bank_chk #(.XLEN(XLEN), .NUM_TRIG(NUM_TRIG)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .csr_we       (csr_we),
    .sel_hit      (sel_hit),
    .trig_ctrl    (trig_ctrl),
    .trig_cmp     (trig_cmp),
    .trig_changed (trig_changed)
);

// File: tb/dtrig_csr_bank_test.sv
module dtrig_csr_bank_test;
    localparam int XLEN = 64;
    localparam int NT   = 2;
    localparam logic [63:0] CTRL_RST = 64'h2000_0000_0000_0000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [11:0]      csr_addr = 12'h000;
    logic [XLEN-1:0]  csr_wdata = '0;
    logic             csr_we = 1'b0;
    logic [XLEN-1:0]  csr_rdata;
    logic [NT*XLEN-1:0] trig_ctrl;
    logic [NT*XLEN-1:0] trig_cmp;
    logic [NT-1:0]    trig_changed;

    int n_tests = 0;
    int n_fail  = 0;
    logic [63:0] m_sel;
    logic [63:0] m_ctrl [NT];
    logic [63:0] m_cmp  [NT];

    always #5 clk = ~clk;

    dtrig_csr_bank uut (
        .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_we(csr_we), .csr_rdata(csr_rdata), .trig_ctrl(trig_ctrl),
        .trig_cmp(trig_cmp), .trig_changed(trig_changed)
    );

    function automatic logic [63:0] legal_of(input logic [63:0] w);
        logic [63:0] r;
        logic [3:0]  c;
        r = CTRL_RST | (w & 64'h5F);
        c = {w[22:21], w[17:16]};
        if (c inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5}) r = r | (w & 64'h0063_0000);
        return r;
    endfunction

    function automatic logic [63:0] read_of(input logic [11:0] a);
        case (a)
            12'h7A0: return m_sel;
            12'h7A1: return (m_sel < 2) ? m_ctrl[m_sel[0]] : 64'd0;
            12'h7A2: return (m_sel < 2) ? m_cmp[m_sel[0]] : 64'd0;
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_exports(input string req);
        for (int i = 0; i < NT; i++) begin
            check(req, trig_ctrl[i*64 +: 64], m_ctrl[i]);
            check(req, trig_cmp[i*64 +: 64], m_cmp[i]);
        end
    endtask

    task automatic rd(input logic [11:0] a, input string req);
        @(negedge clk);
        csr_addr = a;
        csr_we   = 1'b0;
        #1;
        check(req, csr_rdata, read_of(a));
    endtask

    // Write one CSR, update the model and check pulse and exports (R10, R11).
    task automatic wr(input logic [11:0] a, input logic [63:0] d);
        logic [1:0] mask;
        mask = 2'b00;
        @(negedge clk);
        csr_addr  = a;
        csr_wdata = d;
        csr_we    = 1'b1;
        if (a == 12'h7A0) m_sel = d;
        else if (a == 12'h7A1 && m_sel < 2) begin
            if (legal_of(d) != m_ctrl[m_sel[0]]) mask[m_sel[0]] = 1'b1;
            m_ctrl[m_sel[0]] = legal_of(d);
        end else if (a == 12'h7A2 && m_sel < 2) begin
            if (d != m_cmp[m_sel[0]]) mask[m_sel[0]] = 1'b1;
            m_cmp[m_sel[0]] = d;
        end
        @(negedge clk);
        csr_we = 1'b0;
        check("R10 change pulse", trig_changed, mask);
        check_exports("R11 exports");
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        void'($urandom(32'd2024));
        m_sel = '0;
        for (int i = 0; i < NT; i++) begin
            m_ctrl[i] = CTRL_RST;
            m_cmp[i]  = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 changed", trig_changed, 2'b00);
        check_exports("R1 exports");
        rd(12'h7A0, "R1 tselect");
        rd(12'h7A1, "R1 tdata1");

        // R2 full-width selection register
        wr(12'h7A0, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h7A0, "R2 tselect all ones");
        // R8 out of range with high bits set, low bits naming trigger 1
        wr(12'h7A1, 64'h0000_0000_0000_005F);
        wr(12'h7A2, 64'h1234);
        rd(12'h7A1, "R8 tdata1 out of range");
        rd(12'h7A2, "R8 tdata2 out of range");
        rd(12'h7A3, "R8 tdata3 out of range");

        // R3 R4 R5 type pinned, perms kept, reserved cleared
        wr(12'h7A0, 64'd1);
        wr(12'h7A1, 64'hF800_0000_001F_FFFF);
        rd(12'h7A1, "R3 R4 R5 filtered tdata1");
        wr(12'h7A1, 64'h0000_0000_0000_0000);
        rd(12'h7A1, "R4 bits cleared");

        // R6 all sixteen size codes on trigger 0
        wr(12'h7A0, 64'd0);
        for (int c = 0; c < 16; c++) begin
            d = 64'h4D | (64'(c[3:2]) << 21) | (64'(c[1:0]) << 16);
            wr(12'h7A1, d);
            rd(12'h7A1, "R6 size code");
        end

        // R10 identical rewrite gives no pulse
        wr(12'h7A1, 64'h41);
        wr(12'h7A1, 64'hFFFF_0000_0000_FF41);
        wr(12'h7A2, 64'hDEAD_BEEF_0000_0001);
        wr(12'h7A2, 64'hDEAD_BEEF_0000_0001);
        rd(12'h7A2, "R7 tdata2 readback");

        // R9 tdata3 ignored
        wr(12'h7A3, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h7A3, "R9 tdata3 reads zero");
        // R12 unknown address ignored
        wr(12'h7A5, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(12'h7A5, "R12 unknown address");

        // Random mix
        for (int k = 0; k < 600; k++) begin
            int kind;
            kind = int'($urandom % 8);
            d = {$urandom, $urandom};
            case (kind)
                0: wr(12'h7A0, 64'($urandom % 4));
                1: wr(12'h7A0, d);
                2, 3: wr(12'h7A1, d);
                4: wr(12'h7A2, d);
                5: wr(12'h7A3, d);
                6: wr(12'h7A4 + 12'($urandom % 16), d);
                default: wr(12'h7A1, read_of(12'h7A1));
            endcase
            rd(12'h7A0 + 12'($urandom % 4), "R7 R11 random readback");
        end

        finish_run();
    end
endmodule